// File: doc/BRIEF.md
# SPI TPM Target Transaction Engine

This block is the serial front end for TPM-style register traffic arriving on a SPI target port that has its own chip select. Every transaction opens with a four-byte header: one command byte, which carries the direction and the transfer length, followed by a 24-bit address. Written payload bytes are queued for software. Read payloads are built from 32-bit words that software queues, and the block holds the host in wait states until enough words are present.

Software sees three queues. A header queue holds `{command, address}` words and drives the interrupt. A byte queue holds write payload. A word queue holds read response data. A mode input selects between two register interfaces. In the FIFO interface the block answers reads of the hash-start register window by itself, returning 0xFF and inserting no wait state. In the CRB interface every read is passed to software, including reads of that window.

The serial side is oversampled by the system clock. SCK, CS# and MOSI pass through synchronizers and edge detectors, so the serial clock must be several times slower than the system clock.

Top module: `tpm_spi_target`

## Requirements
- R1: Command byte bit 7 selects the direction (1 = read, 0 = write) and bits 5:0 hold the byte count minus one (1 to 64 bytes). The 24-bit address follows, MSB first. For writes and for software-answered reads, the word `{command[7:0], address[23:0]}` is queued on the header queue (`hdr_data_o[31:24]` = command) once the 32nd header bit is received.
- R2: The `length` bytes after the header of a write are queued in order on the write byte queue. Bytes clocked beyond `length` are ignored and do not change `wr_level_o`.
- R3: The bus runs in SPI mode 0. MOSI is sampled MSB first on the SCK rising edge. MISO changes only after an SCK falling edge (or when CS# is asserted). MISO is 0 for all header bits except the last one.
- R4: The last MISO bit of the fourth header byte is the wait flag. It is 1 for writes and for hardware-answered reads, and 0 for software-answered reads.
- R5: After a wait flag of 0, the block sends 0x00 bytes while the read word queue holds fewer than ceil(length/4) words. It then sends one 0x01 byte, followed by the payload. Payload byte k comes from bits [8*(k mod 4)+7 : 8*(k mod 4)] of the current word. A word is removed after its fourth byte or after the last byte of the transfer.
- R6: With `crb_mode_i` = 0, a read whose address bits 23:2 equal those of `HASH_START_ADDR` returns 0xFF for every byte. It is not queued on the header queue and does not remove read words.
- R7: With `crb_mode_i` = 1, a read of the hash-start window is uploaded and answered from the read word queue like any other read.
- R8: `irq_hdr_o` and `hdr_not_empty_o` are 1 exactly while the header queue holds at least one entry.
- R9: The read word queue holds `RD_DEPTH` (16) words. A push while it is full is dropped, and `rd_level_o` reports the word count.
- R10: If CS# is deasserted part way through a byte, the partial bits are discarded and the block returns to idle. The next transaction is framed from its first bit.
- R11: If the read word queue already holds enough words when the header completes, the first byte after the header is 0x01, with no 0x00 bytes before it.
- R12: After reset, MISO is 0, the interrupt is low and all queue levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock (shared with other target functions) |
| csb_i | input | 1 | Dedicated active-low chip select |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| crb_mode_i | input | 1 | 1 = CRB interface, 0 = FIFO interface |
| hdr_pop_i | input | 1 | Remove the head header word |
| hdr_data_o | output | 32 | Head header word `{command, address}` |
| hdr_not_empty_o | output | 1 | Header queue holds an entry |
| wrdata_pop_i | input | 1 | Remove the head write byte |
| wrdata_o | output | 8 | Head write byte |
| wr_level_o | output | $clog2(WR_DEPTH+1) | Write byte queue occupancy |
| rd_push_i | input | 1 | Queue a read response word |
| rd_data_i | input | 32 | Read response word |
| rd_level_o | output | $clog2(RD_DEPTH+1) | Read word queue occupancy |
| irq_hdr_o | output | 1 | Header-not-empty interrupt |

## Verification
The bench loops write payloads back as read responses for every length from 1 to 8 and for 64. This exercises partial final words, where a design that popped only on word boundaries would leave a stale word behind and corrupt the next read. It checks the wait flag and the count of 0x00 wait bytes both with a late software fill and with a pre-filled queue. An off-by-one in the readiness test would either send garbage early or never release the host. Hash-start reads are issued in both modes, and a wrong mode decode would either upload the header or deadlock waiting for data. The bench also overfills the read queue, over-clocks a write past its length, and drops CS# mid-byte, where a careless design would store stray bytes or misframe the next header.

// File: rtl/tpmt_pkg.sv
package tpmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WR,
    ST_WAIT,
    ST_RDY,
    ST_RD,
    ST_HW,
    ST_DONE
  } tpmt_state_e;

  localparam logic [7:0] BYTE_HOLD = 8'h00;
  localparam logic [7:0] BYTE_GO   = 8'h01;
  localparam logic [7:0] BYTE_HASH = 8'hFF;

  // transfer length in bytes from the command byte
  function automatic logic [6:0] cmd_len(input logic [7:0] cmd);
    return {1'b0, cmd[5:0]} + 7'd1;
  endfunction

  // number of 32-bit words covering a transfer
  function automatic logic [4:0] words_for(input logic [6:0] len);
    logic [7:0] tmp;
    tmp = {1'b0, len} + 8'd3;
    return tmp[6:2];
  endfunction

endpackage

// File: rtl/tpmt_sync.sv
module tpmt_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-1:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {(STAGES+1){RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q_o    = chain_q[STAGES-1];
  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/tpmt_fifo.sv
module tpmt_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [LW-1:0]    level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic push_ok, pop_ok;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) wr_ptr_d = bump(wr_ptr_q);
    if (pop_ok)  rd_ptr_d = bump(rd_ptr_q);
    if (push_ok && !pop_ok) cnt_d = cnt_q + LW'(1);
    if (pop_ok && !push_ok) cnt_d = cnt_q - LW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem[rd_ptr_q];
  assign level_o = cnt_q;

  // R9
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH));

  // R9
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (cnt_q == LW'(DEPTH)));
endmodule

// File: rtl/tpm_spi_target.sv
module tpm_spi_target
  import tpmt_pkg::*;
#(
  parameter int unsigned CMD_DEPTH       = 4,
  parameter int unsigned WR_DEPTH        = 64,
  parameter int unsigned RD_DEPTH        = 16,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter logic [23:0] HASH_START_ADDR = 24'hD40028,
  localparam int unsigned WLW            = $clog2(WR_DEPTH + 1),
  localparam int unsigned RLW            = $clog2(RD_DEPTH + 1),
  localparam int unsigned HLW            = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sck_i,
  input  logic           csb_i,
  input  logic           mosi_i,
  output logic           miso_o,
  input  logic           crb_mode_i,
  input  logic           hdr_pop_i,
  output logic [31:0]    hdr_data_o,
  output logic           hdr_not_empty_o,
  input  logic           wrdata_pop_i,
  output logic [7:0]     wrdata_o,
  output logic [WLW-1:0] wr_level_o,
  input  logic           rd_push_i,
  input  logic [31:0]    rd_data_i,
  output logic [RLW-1:0] rd_level_o,
  output logic           irq_hdr_o
);

  // ---------------- input conditioning ----------------
  logic sck_s, sck_rise, sck_fall;
  logic csb_s, csb_rise, csb_fall;
  logic mosi_s, mosi_rise, mosi_fall;

  tpmt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk_i, .rst_ni, .d_i(sck_i), .q_o(sck_s), .rise_o(sck_rise), .fall_o(sck_fall));
  tpmt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csb (
    .clk_i, .rst_ni, .d_i(csb_i), .q_o(csb_s), .rise_o(csb_rise), .fall_o(csb_fall));
  tpmt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk_i, .rst_ni, .d_i(mosi_i), .q_o(mosi_s), .rise_o(mosi_rise), .fall_o(mosi_fall));

  // ---------------- state ----------------
  tpmt_state_e state_q, state_d;
  logic [2:0]  bit_cnt_q, bit_cnt_d;
  logic [1:0]  hbyte_q, hbyte_d;
  logic [31:0] sr_q, sr_d;
  logic [6:0]  len_q, len_d;
  logic [6:0]  cnt_q, cnt_d;
  logic [1:0]  bidx_q, bidx_d;
  logic [7:0]  tx_q, tx_d;
  logic        miso_q, miso_d;

  logic        push_hdr, push_wr, pop_rd;
  logic [31:0] rx_word;
  logic [31:0] rd_head;
  logic [7:0]  slot_byte;
  logic        hw_hit_full, want_wait, rd_ready_q, rd_ready_new, last_byte;
  logic        hdr_empty, hdr_full, wr_full, wr_empty, rd_full, rd_empty;
  logic [HLW-1:0] hdr_level;
  logic [6:0]  cnt_inc;

  assign rx_word  = {sr_q[30:0], mosi_s};
  assign cnt_inc  = cnt_q + 7'd1;
  assign last_byte = (cnt_inc == len_q);

  // full header decode (at the 32nd bit)
  assign hw_hit_full = rx_word[31] && !crb_mode_i &&
                       (rx_word[23:2] == HASH_START_ADDR[23:2]);
  // early decode for the wait flag, 31 bits in hand
  assign want_wait   = sr_q[30] &&
                       !(!crb_mode_i && (sr_q[22:1] == HASH_START_ADDR[23:2]));

  assign rd_ready_q   = int'(rd_level_o) >= int'(words_for(len_q));
  assign rd_ready_new = int'(rd_level_o) >= int'(words_for(cmd_len(rx_word[31:24])));

  always_comb begin
    unique case (state_q)
      ST_RDY:  slot_byte = BYTE_GO;
      ST_RD:   slot_byte = rd_head[8*bidx_q +: 8];
      ST_HW:   slot_byte = BYTE_HASH;
      default: slot_byte = BYTE_HOLD;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    bit_cnt_d = bit_cnt_q;
    hbyte_d   = hbyte_q;
    sr_d      = sr_q;
    len_d     = len_q;
    cnt_d     = cnt_q;
    bidx_d    = bidx_q;
    tx_d      = tx_q;
    miso_d    = miso_q;
    push_hdr  = 1'b0;
    push_wr   = 1'b0;
    pop_rd    = 1'b0;

    if (csb_s) begin
      state_d   = ST_IDLE;
      bit_cnt_d = '0;
      hbyte_d   = '0;
      tx_d      = '0;
      miso_d    = 1'b0;
    end else if (state_q == ST_IDLE) begin
      state_d   = ST_HDR;
      bit_cnt_d = '0;
      hbyte_d   = '0;
      tx_d      = '0;
      miso_d    = 1'b0;
    end else begin
      if (sck_rise) begin
        sr_d      = rx_word;
        bit_cnt_d = bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          unique case (state_q)
            ST_HDR: begin
              if (hbyte_q == 2'd3) begin
                len_d  = cmd_len(rx_word[31:24]);
                cnt_d  = '0;
                bidx_d = '0;
                if (!rx_word[31]) begin
                  state_d  = ST_WR;
                  push_hdr = 1'b1;
                end else if (hw_hit_full) begin
                  state_d = ST_HW;
                end else begin
                  push_hdr = 1'b1;
                  state_d  = rd_ready_new ? ST_RDY : ST_WAIT;
                end
              end else begin
                hbyte_d = hbyte_q + 2'd1;
              end
            end
            ST_WR: begin
              push_wr = 1'b1;
              cnt_d   = cnt_inc;
              if (last_byte) state_d = ST_DONE;
            end
            ST_WAIT: if (rd_ready_q) state_d = ST_RDY;
            ST_RDY:  state_d = ST_RD;
            ST_RD: begin
              pop_rd = (bidx_q == 2'd3) || last_byte;
              bidx_d = bidx_q + 2'd1;
              cnt_d  = cnt_inc;
              if (last_byte) state_d = ST_DONE;
            end
            ST_HW: begin
              cnt_d = cnt_inc;
              if (last_byte) state_d = ST_DONE;
            end
            default: ;
          endcase
        end
      end
      if (sck_fall) begin
        if (bit_cnt_q == 3'd0) begin
          miso_d = slot_byte[7];
          tx_d   = {slot_byte[6:0], 1'b0};
        end else if (state_q == ST_HDR && hbyte_q == 2'd3 && bit_cnt_q == 3'd7) begin
          miso_d = ~want_wait;
          tx_d   = {tx_q[6:0], 1'b0};
        end else begin
          miso_d = tx_q[7];
          tx_d   = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      hbyte_q   <= '0;
      sr_q      <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
      bidx_q    <= '0;
      tx_q      <= '0;
      miso_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      hbyte_q   <= hbyte_d;
      sr_q      <= sr_d;
      len_q     <= len_d;
      cnt_q     <= cnt_d;
      bidx_q    <= bidx_d;
      tx_q      <= tx_d;
      miso_q    <= miso_d;
    end
  end

  // ---------------- queues ----------------
  tpmt_fifo #(.WIDTH(32), .DEPTH(CMD_DEPTH)) u_hdr_q (
    .clk_i, .rst_ni, .push_i(push_hdr), .wdata_i(rx_word), .pop_i(hdr_pop_i),
    .rdata_o(hdr_data_o), .level_o(hdr_level), .full_o(hdr_full), .empty_o(hdr_empty));

  tpmt_fifo #(.WIDTH(8), .DEPTH(WR_DEPTH)) u_wr_q (
    .clk_i, .rst_ni, .push_i(push_wr), .wdata_i(rx_word[7:0]), .pop_i(wrdata_pop_i),
    .rdata_o(wrdata_o), .level_o(wr_level_o), .full_o(wr_full), .empty_o(wr_empty));

  tpmt_fifo #(.WIDTH(32), .DEPTH(RD_DEPTH)) u_rd_q (
    .clk_i, .rst_ni, .push_i(rd_push_i), .wdata_i(rd_data_i), .pop_i(pop_rd),
    .rdata_o(rd_head), .level_o(rd_level_o), .full_o(rd_full), .empty_o(rd_empty));

  logic unused_sigs;
  assign unused_sigs = csb_rise ^ csb_fall ^ mosi_rise ^ mosi_fall ^
                       hdr_full ^ wr_full ^ wr_empty ^ rd_full;

  assign miso_o          = miso_q;
  assign hdr_not_empty_o = ~hdr_empty;
  assign irq_hdr_o       = ~hdr_empty;

  // ---------------- assertions ----------------
  // R8
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hdr_o == (hdr_level != '0));

  // R5
  rd_pop_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_rd |-> !rd_empty);

  // R2
  xfer_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_WR, ST_RD, ST_HW}) |-> (cnt_q < len_q));

  // R3
  miso_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csb_s && sck_s && $past(sck_s) && $past(!csb_s)) |-> $stable(miso_q));

  // R6
  hw_no_upload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HW) |=> (hdr_level <= $past(hdr_level)));
endmodule

// File: tb/tpm_spi_target_tb.sv
module tpm_spi_target_tb;
  localparam int HALF = 8;
  localparam logic [23:0] HASH = 24'hD40028;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csb = 1'b1, mosi = 1'b0, crb = 1'b0;
  logic hdr_pop = 1'b0, wr_pop = 1'b0, rd_push = 1'b0;
  logic [31:0] rd_data = '0;
  logic miso, hdr_ne, irq;
  logic [31:0] hdr_data;
  logic [7:0]  wrdata;
  logic [6:0]  wr_level;
  logic [4:0]  rd_level;

  always #5 clk = ~clk;

  tpm_spi_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csb_i(csb), .mosi_i(mosi),
    .miso_o(miso), .crb_mode_i(crb), .hdr_pop_i(hdr_pop), .hdr_data_o(hdr_data),
    .hdr_not_empty_o(hdr_ne), .wrdata_pop_i(wr_pop), .wrdata_o(wrdata),
    .wr_level_o(wr_level), .rd_push_i(rd_push), .rd_data_i(rd_data),
    .rd_level_o(rd_level), .irq_hdr_o(irq));

  int n_cmp = 0, n_bad = 0;
  int nwait = 0;
  logic wflag;
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic spi_open();
    csb = 1'b0;
    tick(HALF);
  endtask

  task automatic spi_close();
    tick(HALF);
    csb  = 1'b1;
    mosi = 1'b0;
    tick(4 * HALF);
  endtask

  task automatic host_header(input logic [7:0] cmd, input logic [23:0] addr);
    logic [7:0] b;
    logic [31:0] h;
    h = {cmd, addr};
    for (int k = 0; k < 4; k++) begin
      spi_bits(h[31-8*k -: 8], 8, b);
      if (k < 3) check("R3 header miso byte", {24'h0, b}, 32'h0);
      else begin
        check("R3 header miso flag byte", {25'h0, b[7:1]}, 32'h0);
        wflag = b[0];
      end
    end
  endtask

  task automatic host_write(input logic [23:0] addr, input int len, input int extra);
    logic [7:0] b;
    spi_open();
    host_header(8'(len - 1), addr);
    check("R4 write wait flag", {31'h0, wflag}, 32'h1);
    for (int i = 0; i < len + extra; i++) spi_bits((i < len) ? wbuf[i] : 8'h5A, 8, b);
    spi_close();
  endtask

  task automatic host_read(input logic [23:0] addr, input int len, input logic exp_flag);
    logic [7:0] b;
    nwait = 0;
    spi_open();
    host_header(8'h80 | 8'(len - 1), addr);
    check("R4 read wait flag", {31'h0, wflag}, {31'h0, exp_flag});
    if (!wflag) begin
      for (int t = 0; t < 400; t++) begin
        spi_bits(8'h00, 8, b);
        if (b == 8'h01) break;
        check("R5 wait byte value", {24'h0, b}, 32'h0);
        nwait++;
      end
    end
    for (int i = 0; i < len; i++) spi_bits(8'h00, 8, rbuf[i]);
    spi_close();
  endtask

  task automatic sw_pop_hdr(output logic [31:0] w);
    for (int t = 0; t < 20000 && !hdr_ne; t++) tick(1);
    w = hdr_data;
    hdr_pop = 1'b1;
    tick(1);
    hdr_pop = 1'b0;
    tick(1);
  endtask

  task automatic sw_fill(input int len, input int nwords);
    for (int w = 0; w < nwords; w++) begin
      logic [31:0] word;
      for (int k = 0; k < 4; k++)
        word[8*k +: 8] = (4*w + k < len) ? wbuf[4*w + k] : 8'h00;
      rd_data = word;
      rd_push = 1'b1;
      tick(1);
      rd_push = 1'b0;
      tick(1);
    end
  endtask

  task automatic loopback(input int len, input logic [23:0] addr);
    logic [31:0] h;
    for (int i = 0; i < len; i++) wbuf[i] = 8'((len * 17 + i * 29 + 3) & 8'hFF);
    host_write(addr, len, 0);
    check("R8 irq after write header", {31'h0, irq}, 32'h1);
    sw_pop_hdr(h);
    check("R1 write header word", h, {8'(len - 1), addr});
    check("R8 irq cleared", {31'h0, irq}, 32'h0);
    check("R2 write level", {25'h0, wr_level}, 32'(len));
    for (int i = 0; i < len; i++) begin
      check("R2 write byte", {24'h0, wrdata}, {24'h0, wbuf[i]});
      wr_pop = 1'b1;
      tick(1);
      wr_pop = 1'b0;
      tick(1);
    end
    fork
      host_read(addr, len, 1'b0);
      begin
        logic [31:0] hr;
        sw_pop_hdr(hr);
        check("R1 read header word", hr, {8'h80 | 8'(len - 1), addr});
        tick(20);
        sw_fill(len, (len + 3) / 4);
      end
    join
    check("R5 wait bytes seen", {31'h0, nwait >= 1}, 32'h1);
    for (int i = 0; i < len; i++) check("R5 loopback byte", {24'h0, rbuf[i]}, {24'h0, wbuf[i]});
    check("R5 read words all consumed", {27'h0, rd_level}, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] h;
    logic [7:0] b;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R12 reset state
    check("R12 miso reset", {31'h0, miso}, 32'h0);
    check("R12 irq reset", {31'h0, irq}, 32'h0);
    check("R12 hdr empty reset", {31'h0, hdr_ne}, 32'h0);
    check("R12 wr level reset", {25'h0, wr_level}, 32'h0);
    check("R12 rd level reset", {27'h0, rd_level}, 32'h0);

    // R1 R2 R4 R5: loopback sweep
    for (int len = 1; len <= 8; len++) loopback(len, 24'h000100 + 24'(len * 4));
    loopback(64, 24'hD40024);

    // R2 bytes beyond length ignored
    for (int i = 0; i < 2; i++) wbuf[i] = 8'(8'hC0 + i);
    host_write(24'h000200, 2, 3);
    check("R2 extra bytes ignored", {25'h0, wr_level}, 32'h2);
    sw_pop_hdr(h);
    for (int i = 0; i < 2; i++) begin
      wr_pop = 1'b1; tick(1); wr_pop = 1'b0; tick(1);
    end

    // R9 overfill read queue, R11 prefilled read
    for (int i = 0; i < 64; i++) wbuf[i] = 8'((i * 7 + 1) & 8'hFF);
    sw_fill(64, 16);
    rd_data = 32'hDEADBEEF; rd_push = 1'b1; tick(1); rd_push = 1'b0; tick(1);
    check("R9 read queue caps", {27'h0, rd_level}, 32'd16);
    host_read(24'h000300, 64, 1'b0);
    check("R11 no wait bytes when prefilled", 32'(nwait), 32'h0);
    for (int i = 0; i < 64; i++) check("R9 overflow word dropped", {24'h0, rbuf[i]}, {24'h0, wbuf[i]});
    check("R9 read queue drained", {27'h0, rd_level}, 32'h0);
    sw_pop_hdr(h);
    check("R1 prefilled read header", h, {8'hBF, 24'h000300});

    // R6 FIFO mode hash-start reads
    crb = 1'b0;
    host_read(HASH + 24'd1, 4, 1'b1);
    for (int i = 0; i < 4; i++) check("R6 hash byte", {24'h0, rbuf[i]}, 32'hFF);
    check("R6 no upload", {31'h0, hdr_ne}, 32'h0);
    host_read(HASH, 3, 1'b1);
    for (int i = 0; i < 3; i++) check("R6 hash byte", {24'h0, rbuf[i]}, 32'hFF);
    check("R6 no upload", {31'h0, irq}, 32'h0);

    // R7 CRB mode uploads hash-start read
    crb = 1'b1;
    wbuf[0] = 8'hD4; wbuf[1] = 8'hC3;
    fork
      host_read(HASH, 2, 1'b0);
      begin
        logic [31:0] hr;
        sw_pop_hdr(hr);
        check("R7 crb header uploaded", hr, {8'h81, HASH});
        tick(10);
        sw_fill(2, 1);
      end
    join
    check("R7 crb data byte0", {24'h0, rbuf[0]}, 32'hD4);
    check("R7 crb data byte1", {24'h0, rbuf[1]}, 32'hC3);
    crb = 1'b0;

    // R10 partial byte on deassert
    spi_open();
    spi_bits(8'h00, 8, b);
    spi_bits(8'hF0, 4, b);
    spi_close();
    check("R10 partial no header", {31'h0, hdr_ne}, 32'h0);
    check("R10 partial no data", {25'h0, wr_level}, 32'h0);
    wbuf[0] = 8'h3C;
    host_write(24'h00ABCD, 1, 0);
    sw_pop_hdr(h);
    check("R10 next header framed", h, {8'h00, 24'h00ABCD});
    check("R10 next data", {24'h0, wrdata}, 32'h3C);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule